// File: doc/BRIEF.md
# Word-to-Character Output Serializer

This block takes a 24-bit word from a host and sends it to an external character device as one to four 6-bit characters. Each character goes out with a parity bit that the block generates. The characters leave highest-order first. The host chooses the number of characters per word when it connects the channel. After the last character of a word has been handed over, the block asks for a new word. If the device asks for a character while no word is held, the block sends a blank character so that the device is never stalled.

A session starts with a connect command. It ends in one of two ways. An abort disconnects at once and throws away any characters not yet sent, with no completion event. A graceful terminate lets the rest of the current word drain, pulses an end-of-record marker, and then disconnects with a one-cycle completion pulse.

Top module: `char_out_serializer`

## Requirements
- R1: Out of reset the channel is disconnected. A `cmd_start` seen while disconnected latches `cfg_chars` (00 = one character, 01 = two, 10 = three, 11 = four per word). In the next cycle `connected` and `word_ready` are both high.
- R2: Every character strobed out carries a parity bit that makes the number of ones across the 6 data bits and the parity bit odd.
- R3: The characters of a word go out left to right: bits 23:18 first, then 17:12, then 11:6, then 5:0, stopping after the configured count. In one-character mode only bits 23:18 are sent.
- R4: A word is accepted only on a cycle where `word_valid` and `word_ready` are both high. `word_ready` is low in the cycle after a load. It is high again in the cycle in which the strobe for the word's last character appears.
- R5: A `dev_req` sampled at a clock edge while the channel is running yields `dev_strobe` high for exactly the following cycle, with `dev_char` and `dev_par` valid in that cycle.
- R6: A request served while no word is held sends a blank: data 000000 with parity bit 1.
- R7: While disconnected, `dev_req` is ignored and no strobe appears.
- R8: `cmd_disc` while connected drops `connected` in the next cycle. It discards any unsent characters, so that after a new connect the first request yields a blank. It produces neither `eor_pulse` nor `done_pulse`.
- R9: After `cmd_term`, `word_ready` stays low and the remaining characters of the held word are still served. Once the buffer is empty, `eor_pulse` is high for one cycle. In the next cycle `done_pulse` is high for one cycle and `connected` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_chars | input | 2 | Characters per word minus one, latched at connect |
| cmd_start | input | 1 | Connect the channel |
| cmd_disc | input | 1 | Abort: disconnect at once, discard unsent characters |
| cmd_term | input | 1 | Graceful terminate: drain, end-of-record, then disconnect |
| word_valid | input | 1 | Host offers a word |
| word_data | input | 24 | Word to serialize |
| word_ready | output | 1 | Buffer empty and channel running; a word may be loaded |
| dev_req | input | 1 | Device requests the next character |
| dev_strobe | output | 1 | Character valid on `dev_char`/`dev_par` |
| dev_char | output | 6 | Character data |
| dev_par | output | 1 | Odd parity bit for `dev_char` |
| eor_pulse | output | 1 | One-cycle end-of-record marker during terminate |
| done_pulse | output | 1 | One-cycle completion after a graceful terminate |
| connected | output | 1 | Channel is connected |

## Verification
The assertions assume that the host asserts at most one of `cmd_start`, `cmd_disc` and `cmd_term` in a cycle. They also assume the host never offers a word in the same cycle as an abort. The bench drives each command as a single isolated one-cycle pulse and raises `word_valid` only after it has seen `word_ready` high. Device requests are spaced two cycles apart, and every strobe is matched against a scoreboard queue. The bench fills that queue from its own model of which word is held and how many of its characters remain.

// File: rtl/ser_pkg.sv
package ser_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2,
    ST_EOR   = 2'd3
  } ser_state_e;
endpackage

// File: rtl/ser_word_buf.sv
module ser_word_buf #(
  parameter int CHAR_W    = 6,
  parameter int MAX_CHARS = 4,
  localparam int WORD_W   = CHAR_W * MAX_CHARS,
  localparam int IDX_W    = (MAX_CHARS > 1) ? $clog2(MAX_CHARS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic [IDX_W-1:0]  cfg_last,
  input  logic              take,
  output logic              full,
  output logic              at_last,
  output logic [CHAR_W-1:0] cur_char
);
  logic [WORD_W-1:0] word_q;
  logic [IDX_W-1:0]  idx_q;
  logic              full_q;

  // character i of the word counted from the high-order end
  function automatic logic [CHAR_W-1:0] pick_char(input logic [WORD_W-1:0] w,
                                                  input logic [IDX_W-1:0]  i);
    logic [WORD_W-1:0] sh;
    sh = w >> (CHAR_W * (MAX_CHARS - 1 - int'(i)));
    return sh[CHAR_W-1:0];
  endfunction

  assign full     = full_q;
  assign at_last  = (idx_q == cfg_last);
  assign cur_char = pick_char(word_q, idx_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q <= '0;
      idx_q  <= '0;
      full_q <= 1'b0;
    end else if (clear) begin
      idx_q  <= '0;
      full_q <= 1'b0;
    end else if (load) begin
      word_q <= load_word;
      idx_q  <= '0;
      full_q <= 1'b1;
    end else if (take) begin
      if (at_last) begin
        idx_q  <= '0;
        full_q <= 1'b0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ser_ctrl.sv
module ser_ctrl
  import ser_pkg::*;
#(
  parameter int MAX_CHARS = 4,
  localparam int IDX_W    = (MAX_CHARS > 1) ? $clog2(MAX_CHARS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_start,
  input  logic             cmd_disc,
  input  logic             cmd_term,
  input  logic [IDX_W-1:0] cfg_chars,
  input  logic             buf_full,
  input  logic             dev_req,
  output logic [IDX_W-1:0] cfg_last,
  output logic             connected,
  output logic             word_ready,
  output logic             take_evt,
  output logic             blank_evt,
  output logic             abort_evt,
  output logic             buf_clear,
  output logic             eor_evt,
  output logic             done_evt
);
  ser_state_e       state_q, state_d;
  logic [IDX_W-1:0] cfg_q;
  logic             done_q;
  logic             serving;

  assign connected  = (state_q != ST_IDLE);
  assign abort_evt  = connected && cmd_disc;
  assign serving    = !abort_evt && dev_req &&
                      ((state_q == ST_RUN) || (state_q == ST_DRAIN));
  assign take_evt   = serving && buf_full;
  assign blank_evt  = serving && !buf_full && (state_q == ST_RUN);
  assign word_ready = (state_q == ST_RUN) && !buf_full;
  assign buf_clear  = abort_evt || (state_q == ST_IDLE);
  assign eor_evt    = (state_q == ST_EOR);
  assign done_evt   = done_q;
  assign cfg_last   = cfg_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (cmd_start) state_d = ST_RUN;
      ST_RUN:   if (abort_evt) state_d = ST_IDLE;
                else if (cmd_term) state_d = ST_DRAIN;
      ST_DRAIN: if (abort_evt) state_d = ST_IDLE;
                else if (!buf_full) state_d = ST_EOR;
      ST_EOR:   state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cfg_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (state_q == ST_EOR) && !abort_evt;
      if ((state_q == ST_IDLE) && cmd_start) cfg_q <= cfg_chars;
    end
  end
endmodule

// File: rtl/ser_char_out.sv
module ser_char_out #(
  parameter int CHAR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              blank,
  input  logic [CHAR_W-1:0] cur_char,
  output logic              strobe,
  output logic [CHAR_W-1:0] char_o,
  output logic              par_o
);
  // bit that makes the total count of ones odd
  function automatic logic odd_fill(input logic [CHAR_W-1:0] c);
    return ~(^c);
  endfunction

  logic [CHAR_W-1:0] next_char;
  assign next_char = blank ? '0 : cur_char;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strobe <= 1'b0;
      char_o <= '0;
      par_o  <= 1'b0;
    end else begin
      strobe <= take || blank;
      if (take || blank) begin
        char_o <= next_char;
        par_o  <= odd_fill(next_char);
      end
    end
  end
endmodule

// File: rtl/char_out_serializer.sv
module char_out_serializer #(
  parameter int CHAR_W    = 6,
  parameter int MAX_CHARS = 4,
  localparam int WORD_W   = CHAR_W * MAX_CHARS,
  localparam int IDX_W    = (MAX_CHARS > 1) ? $clog2(MAX_CHARS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  cfg_chars,
  input  logic              cmd_start,
  input  logic              cmd_disc,
  input  logic              cmd_term,
  input  logic              word_valid,
  input  logic [WORD_W-1:0] word_data,
  output logic              word_ready,
  input  logic              dev_req,
  output logic              dev_strobe,
  output logic [CHAR_W-1:0] dev_char,
  output logic              dev_par,
  output logic              eor_pulse,
  output logic              done_pulse,
  output logic              connected
);
  logic             buf_full, at_last, take_evt, blank_evt, abort_evt, buf_clear;
  logic             word_load;
  logic [IDX_W-1:0] cfg_last;
  logic [CHAR_W-1:0] cur_char;

  assign word_load = word_valid && word_ready;

  ser_ctrl #(.MAX_CHARS(MAX_CHARS)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cmd_start(cmd_start), .cmd_disc(cmd_disc), .cmd_term(cmd_term),
    .cfg_chars(cfg_chars), .buf_full(buf_full), .dev_req(dev_req),
    .cfg_last(cfg_last), .connected(connected), .word_ready(word_ready),
    .take_evt(take_evt), .blank_evt(blank_evt), .abort_evt(abort_evt),
    .buf_clear(buf_clear), .eor_evt(eor_pulse), .done_evt(done_pulse)
  );

  ser_word_buf #(.CHAR_W(CHAR_W), .MAX_CHARS(MAX_CHARS)) u_buf (
    .clk(clk), .rst_n(rst_n), .clear(buf_clear), .load(word_load),
    .load_word(word_data), .cfg_last(cfg_last), .take(take_evt),
    .full(buf_full), .at_last(at_last), .cur_char(cur_char)
  );

  ser_char_out #(.CHAR_W(CHAR_W)) u_out (
    .clk(clk), .rst_n(rst_n), .take(take_evt), .blank(blank_evt),
    .cur_char(cur_char), .strobe(dev_strobe), .char_o(dev_char), .par_o(dev_par)
  );
endmodule

// File: rtl/ser_checker.sv
module ser_checker #(
  parameter int CHAR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_disc,
  input logic              connected,
  input logic              word_ready,
  input logic              word_load,
  input logic              blank_evt,
  input logic              abort_evt,
  input logic              dev_strobe,
  input logic [CHAR_W-1:0] dev_char,
  input logic              dev_par,
  input logic              eor_pulse,
  input logic              done_pulse
);
  assert_odd_parity_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dev_strobe |-> ((^{dev_char, dev_par}) == 1'b1));

  assert_load_drops_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    word_load |=> !word_ready);

  assert_ready_needs_link_R4: assert property (@(posedge clk) disable iff (!rst_n)
    word_ready |-> connected);

  assert_blank_is_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    blank_evt |=> (dev_strobe && (dev_char == '0)));

  assert_quiet_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !connected |=> !dev_strobe);

  assert_abort_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> (!connected && !done_pulse && !eor_pulse));

  assert_eor_then_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (eor_pulse && !cmd_disc) |=> (done_pulse && !connected));

  assert_done_after_eor_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> $past(eor_pulse));
endmodule

bind char_out_serializer ser_checker #(.CHAR_W(CHAR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_disc(cmd_disc), .connected(connected),
  .word_ready(word_ready), .word_load(word_load), .blank_evt(blank_evt),
  .abort_evt(abort_evt), .dev_strobe(dev_strobe), .dev_char(dev_char),
  .dev_par(dev_par), .eor_pulse(eor_pulse), .done_pulse(done_pulse)
);

// File: tb/tb_char_out_serializer.sv
module tb_char_out_serializer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  cfg_chars;
  logic        cmd_start, cmd_disc, cmd_term, word_valid, dev_req;
  logic [23:0] word_data;
  logic        word_ready, dev_strobe, dev_par, eor_pulse, done_pulse, connected;
  logic [5:0]  dev_char;

  int n_chk = 0;
  int n_fail = 0;
  int eor_cnt = 0;
  int done_cnt = 0;
  bit running = 0;
  logic [5:0] exp_q[$];
  logic [5:0] pend[$];

  always #4 clk = ~clk;

  char_out_serializer dut (
    .clk(clk), .rst_n(rst_n), .cfg_chars(cfg_chars), .cmd_start(cmd_start),
    .cmd_disc(cmd_disc), .cmd_term(cmd_term), .word_valid(word_valid),
    .word_data(word_data), .word_ready(word_ready), .dev_req(dev_req),
    .dev_strobe(dev_strobe), .dev_char(dev_char), .dev_par(dev_par),
    .eor_pulse(eor_pulse), .done_pulse(done_pulse), .connected(connected)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // monitor: pops the scoreboard on every strobe
  always @(negedge clk) begin
    if (rst_n) begin
      if (eor_pulse) eor_cnt++;
      if (done_pulse) done_cnt++;
      if (dev_strobe) begin
        if (exp_q.size() == 0) begin
          chk(0, "R7", "unexpected strobe", int'(dev_char), -1);
        end else begin
          logic [5:0] e;
          int ones;
          e = exp_q.pop_front();
          chk(dev_char == e, "R3", "character value", int'(dev_char), int'(e));
          ones = $countones({dev_char, dev_par});
          chk(ones % 2 == 1, "R2", "ones count with parity", ones, 1);
        end
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic do_start(input logic [1:0] cfg);
    cfg_chars = cfg; cmd_start = 1; tick(); cmd_start = 0;
    running = 1;
    @(negedge clk);
    chk(connected == 1, "R1", "connected after start", int'(connected), 1);
    chk(word_ready == 1, "R1", "ready after start", int'(word_ready), 1);
    tick();
  endtask

  task automatic do_load(input logic [23:0] w, input int nch);
    chk(word_ready == 1, "R4", "ready before load", int'(word_ready), 1);
    word_data = w; word_valid = 1; tick(); word_valid = 0;
    for (int i = 0; i < nch; i++) pend.push_back(w[23 - 6*i -: 6]);
    @(negedge clk);
    chk(word_ready == 0, "R4", "ready low after load", int'(word_ready), 0);
    tick();
  endtask

  task automatic do_req();
    dev_req = 1;
    if (pend.size() > 0) exp_q.push_back(pend.pop_front());
    else if (running) exp_q.push_back(6'd0); // R6 blank
    tick(); dev_req = 0; tick();
  endtask

  task automatic do_disc();
    cmd_disc = 1; tick(); cmd_disc = 0;
    pend.delete(); running = 0;
    @(negedge clk);
    chk(connected == 0, "R8", "link down after abort", int'(connected), 0);
    tick();
  endtask

  task automatic wait_eor_done();
    bit seen = 0;
    for (int k = 0; k < 20 && !seen; k++) begin
      @(negedge clk);
      if (eor_pulse) seen = 1;
    end
    chk(seen, "R9", "end-of-record pulse seen", int'(seen), 1);
    @(negedge clk);
    chk(done_pulse == 1, "R9", "done after eor", int'(done_pulse), 1);
    chk(connected == 0, "R9", "link down at done", int'(connected), 0);
    chk(eor_pulse == 0, "R9", "eor one cycle", int'(eor_pulse), 0);
    @(negedge clk);
    chk(done_pulse == 0, "R9", "done one cycle", int'(done_pulse), 0);
    tick();
  endtask

  initial begin
    #1600000;
    chk(0, "WD", "watchdog expired", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int e0, d0;
    rst_n = 0; cfg_chars = 0; cmd_start = 0; cmd_disc = 0; cmd_term = 0;
    word_valid = 0; word_data = 0; dev_req = 0;
    repeat (3) tick();
    chk(connected == 0, "R1", "reset link", int'(connected), 0);
    chk(word_ready == 0, "R1", "reset ready", int'(word_ready), 0);
    chk(dev_strobe == 0, "R5", "reset strobe", int'(dev_strobe), 0);
    rst_n = 1; tick();

    do_req();                          // R7: ignored while disconnected

    do_start(2'b11);                   // four characters
    do_load(24'hA53CF1, 4);
    repeat (3) do_req();
    dev_req = 1; exp_q.push_back(pend.pop_front()); tick(); dev_req = 0;
    @(negedge clk);
    chk(dev_strobe == 1, "R5", "strobe cycle after request", int'(dev_strobe), 1);
    chk(word_ready == 1, "R4", "ready with last strobe", int'(word_ready), 1);
    tick();
    @(negedge clk);
    chk(dev_strobe == 0, "R5", "strobe lasts one cycle", int'(dev_strobe), 0);
    tick();
    do_req();                          // R6: underflow blank
    do_load(24'h123456, 4);
    repeat (4) do_req();
    do_disc();

    do_start(2'b00);                   // R3 one character
    do_load(24'hFC0FFF, 1);
    do_req();
    chk(word_ready == 1, "R4", "ready after single char", int'(word_ready), 1);
    do_req();
    do_disc();

    do_start(2'b01);
    do_load(24'h00C03F, 2);
    repeat (3) do_req();
    do_disc();
    do_start(2'b10);
    do_load(24'hFEDCBA, 3);
    repeat (3) do_req();
    do_disc();

    do_start(2'b11);                   // R9 terminate with pending chars
    do_load(24'h7E81C3, 4);
    do_req();
    cmd_term = 1; tick(); cmd_term = 0; running = 0;
    @(negedge clk);
    chk(word_ready == 0, "R9", "no ready while draining", int'(word_ready), 0);
    tick();
    repeat (3) do_req();
    wait_eor_done();

    do_start(2'b01);                   // R9 terminate with empty buffer
    cmd_term = 1; tick(); cmd_term = 0; running = 0;
    wait_eor_done();

    do_start(2'b11);                   // R8 abort with pending chars
    do_load(24'h555AAA, 4);
    do_req();
    e0 = eor_cnt; d0 = done_cnt;
    do_disc();
    repeat (10) tick();
    chk(eor_cnt == e0, "R8", "no eor after abort", eor_cnt - e0, 0);
    chk(done_cnt == d0, "R8", "no done after abort", done_cnt - d0, 0);
    do_req();                          // ignored, disconnected
    do_start(2'b11);
    do_req();                          // R8: discarded word gives blank

    repeat (4) tick();
    chk(exp_q.size() == 0, "R5", "scoreboard drained", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule